// File: doc/BRIEF.md
# Audio Frame Clock Divider with Gating

This block takes a running master audio clock and produces three outputs from it: a gated copy of the master clock, a bit clock divided down from it, and a frame clock (the left/right word clock) that lasts 64 bit clocks. A two-bit speed code sets how many master clock cycles make one bit clock. The frame is always 64 bit clocks long, so the same master clock serves four sample rates. In the fastest setting the bit clock is the master clock itself.

Every output has its own disable input that holds it low. Switching a gate on or off never cuts a pulse short and never adds a narrow one. The three outputs fall together: a bit clock falling edge always lines up with a master clock falling edge, and the frame clock only moves when the bit clock falls. Software is expected to disable the outputs before changing the speed code. The divider also defers any speed change to the next frame boundary, so no frame is ever made partly at one rate and partly at another.

All internal state is clocked on the falling edge of the master clock. That is the edge at which the divided outputs change and at which the gates take a new enable.

Top module: `audio_frame_clkgen`

## Requirements
- R1: `speed_sel` sets the number of master clock cycles in one bit clock period: 00 gives 8, 01 gives 4, 10 gives 2 and 11 gives 1.
- R2: One period of `frame_out` spans exactly 64 periods of `bclk_out`. The frame clock is high for 32 of them and low for the other 32.
- R3: `bclk_out` is high for exactly half of its period.
- R4: When an `*_off` input is 1, its gate closes at the next falling master clock edge at which that output is low. While the gate is closed, that output stays low.
- R5: `frame_out` changes level only at an instant where `bclk_out` falls.
- R6: Every falling edge of `bclk_out` coincides with a falling edge of `mclk_out`. The low phase of the frame clock begins together with a bit clock falling edge.
- R7: Opening or closing a gate never shortens a high pulse. Each high phase is complete: half a bit period for `bclk_out`, one master high phase for `mclk_out`, and 32 bit periods for `frame_out`.
- R8: A new `speed_sel` value takes effect only at the next frame boundary. Every high or low phase of `frame_out` has either the old length or the new length, never a mixture.
- R9: With `speed_sel` = 11, `bclk_out` carries the same level as `mclk_out` in every half cycle.
- R10: While `rst_n` is 0, all outputs are low and every gate is closed, whatever the `*_off` inputs are. After release the speed setting is 00, and a gate whose `*_off` input is 0 opens at the first falling master clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk_in | input | 1 | Master audio clock; the block divides this clock and gates it |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 2 | Speed code that sets the master-to-bit-clock ratio (R1) |
| mclk_off | input | 1 | 1 holds `mclk_out` low |
| bclk_off | input | 1 | 1 holds `bclk_out` low |
| frame_off | input | 1 | 1 holds `frame_out` low |
| mclk_out | output | 1 | Gated master clock |
| bclk_out | output | 1 | Gated bit clock |
| frame_out | output | 1 | Gated frame (left/right) clock, 64 bit clocks per period |

## Verification
The assertions check four rules on every falling master edge: the active speed code loads only at a frame wrap, the internal frame level moves only together with a bit-level fall, a gate's enable changes only while its output is low, and a closed gate keeps its registered output low. The ratios, duty cycles and edge alignment of the three outputs in each speed mode can only be shown by the bench, which samples every half cycle. The same holds for full-length pulses while gates toggle at odd moments, clean frame lengths across a speed change made while the outputs run, the pass-through in the fastest mode, and the behaviour during and after reset.

// File: rtl/afgate_pkg.sv
package afgate_pkg;

  // Width of the scratch vectors used by the arithmetic helpers.
  localparam int unsigned CW_MAX = 16;

  // Speed code: the master-to-bit-clock ratio halves with each step.
  typedef enum logic [1:0] {
    SPD_X1 = 2'b00,  // 8 master cycles per bit clock
    SPD_X2 = 2'b01,  // 4
    SPD_X4 = 2'b10,  // 2
    SPD_X8 = 2'b11   // 1, bit clock is the master clock
  } speed_e;

  // log2 of the master cycles per bit clock for a speed code.
  function automatic logic [1:0] div_shift(input speed_e s);
    return 2'd3 - 2'(s);
  endfunction

  // Last counter value of a frame, counted in master cycles.
  function automatic logic [CW_MAX-1:0] frame_last(input logic [1:0] sh,
                                                   input int unsigned frame_bclks);
    return CW_MAX'((frame_bclks << sh) - 1);
  endfunction

  // Bit clock level for a master-cycle count: the upper half of each
  // bit period is high, so a bit period starts with its falling edge.
  function automatic logic bclk_level(input logic [CW_MAX-1:0] cnt,
                                      input logic [1:0] sh);
    logic [CW_MAX-1:0] t;
    if (sh == 2'd0) return 1'b0;
    t = cnt >> (sh - 2'd1);
    return t[0];
  endfunction

  // Frame level: high over the second half of the bit clocks in a frame.
  function automatic logic frame_level(input logic [CW_MAX-1:0] cnt,
                                       input logic [1:0] sh,
                                       input int unsigned frame_bclks);
    logic [CW_MAX-1:0] idx;
    idx = cnt >> sh;
    return idx >= CW_MAX'(frame_bclks / 2);
  endfunction

endpackage

// File: rtl/afgate_sequencer.sv
module afgate_sequencer
  import afgate_pkg::*;
#(
  parameter int unsigned FRAME_BCLKS = 64,
  parameter int unsigned MAX_DIV     = 8,
  localparam int unsigned CNT_W      = $clog2(FRAME_BCLKS * MAX_DIV)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  speed_e speed_req,
  output logic   bclk_lvl_nxt,
  output logic   frame_lvl_nxt,
  output logic   oct_q
);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [CW_MAX-1:0] cnt_nxt_ext;
  speed_e            speed_q;
  logic [1:0]        sh;
  logic              frame_wrap;
  logic              bclk_lvl_q;
  logic              frame_lvl_q;

  always_comb begin
    sh            = div_shift(speed_q);
    frame_wrap    = (CW_MAX'(cnt_q) == frame_last(sh, FRAME_BCLKS));
    cnt_nxt       = frame_wrap ? '0 : cnt_q + 1'b1;
    cnt_nxt_ext   = CW_MAX'(cnt_nxt);
    bclk_lvl_nxt  = bclk_level(cnt_nxt_ext, sh);
    frame_lvl_nxt = frame_level(cnt_nxt_ext, sh, FRAME_BCLKS);
  end

  assign oct_q = (speed_q == SPD_X8);

  // All state moves on the falling master edge, so every divided edge
  // lines up with a master falling edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      speed_q     <= SPD_X1;
      bclk_lvl_q  <= 1'b0;
      frame_lvl_q <= 1'b0;
    end else begin
      cnt_q       <= cnt_nxt;
      bclk_lvl_q  <= bclk_lvl_nxt;
      frame_lvl_q <= frame_lvl_nxt;
      if (frame_wrap) speed_q <= speed_req;
    end
  end

  AST_SPEED_AT_WRAP: assert property (@(negedge clk) disable iff (!rst_n)
    (speed_q != $past(speed_q)) |-> (cnt_q == '0))
    else $error("speed code loaded away from a frame boundary"); // R8

  AST_FRAME_ON_BCLK_FALL: assert property (@(negedge clk) disable iff (!rst_n)
    (frame_lvl_q != $past(frame_lvl_q)) |-> (!bclk_lvl_q && ($past(bclk_lvl_q) || $past(oct_q))))
    else $error("frame level moved without a bit clock fall"); // R5

endmodule

// File: rtl/afgate_outgate.sv
module afgate_outgate (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_nxt,   // level the output takes at this falling edge
  input  logic off,       // 1 requests the output held low
  input  logic pass,      // 1 forwards the gated clock itself
  output logic clk_out
);

  logic en_q;
  logic out_q;

  // The enable is taken only at falling edges after which the output is
  // low, so an open or close never cuts into a high phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      if (!lvl_nxt) en_q <= !off;
      out_q <= lvl_nxt & en_q;
    end
  end

  assign clk_out = pass ? (clk & en_q) : out_q;

  AST_EN_CHANGES_LOW: assert property (@(negedge clk) disable iff (!rst_n)
    (en_q != $past(en_q)) |-> !out_q)
    else $error("gate enable changed while the output was high"); // R7

  AST_CLOSED_STAYS_LOW: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(off) && !$past(en_q)) |-> !out_q)
    else $error("closed gate let a pulse through"); // R4

endmodule

// File: rtl/audio_frame_clkgen.sv
module audio_frame_clkgen
  import afgate_pkg::*;
#(
  parameter int unsigned FRAME_BCLKS = 64,
  parameter int unsigned MAX_DIV     = 8
) (
  input  logic       mclk_in,
  input  logic       rst_n,
  input  logic [1:0] speed_sel,
  input  logic       mclk_off,
  input  logic       bclk_off,
  input  logic       frame_off,
  output logic       mclk_out,
  output logic       bclk_out,
  output logic       frame_out
);

  localparam int unsigned N_OUT = 3;  // 0: master, 1: bit, 2: frame

  logic             bclk_lvl_nxt;
  logic             frame_lvl_nxt;
  logic             oct_q;
  logic [N_OUT-1:0] lvl_nxt_v;
  logic [N_OUT-1:0] off_v;
  logic [N_OUT-1:0] pass_v;
  logic [N_OUT-1:0] out_v;

  afgate_sequencer #(
    .FRAME_BCLKS (FRAME_BCLKS),
    .MAX_DIV     (MAX_DIV)
  ) u_seq (
    .clk           (mclk_in),
    .rst_n         (rst_n),
    .speed_req     (speed_e'(speed_sel)),
    .bclk_lvl_nxt  (bclk_lvl_nxt),
    .frame_lvl_nxt (frame_lvl_nxt),
    .oct_q         (oct_q)
  );

  // The master gate forwards the clock; in the fastest mode the bit gate
  // does the same, since its divided level is then held at zero.
  assign lvl_nxt_v = {frame_lvl_nxt, bclk_lvl_nxt, 1'b0};
  assign pass_v    = {1'b0, oct_q, 1'b1};
  assign off_v     = {frame_off, bclk_off, mclk_off};

  for (genvar g = 0; g < N_OUT; g++) begin : g_gate
    afgate_outgate u_gate (
      .clk     (mclk_in),
      .rst_n   (rst_n),
      .lvl_nxt (lvl_nxt_v[g]),
      .off     (off_v[g]),
      .pass    (pass_v[g]),
      .clk_out (out_v[g])
    );
  end

  assign mclk_out  = out_v[0];
  assign bclk_out  = out_v[1];
  assign frame_out = out_v[2];

endmodule

// File: tb/audio_frame_clkgen_tb.sv
module audio_frame_clkgen_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] speed_sel;
  logic       mclk_off, bclk_off, frame_off;
  logic       mclk_out, bclk_out, frame_out;

  int errors = 0;
  int checks = 0;

  // Half-cycle samples of the outputs and the samples before them.
  logic cm, cb, cf, pm, pb, pf;

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] bclk_halves;  // half master cycles per bit clock period
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{mode: 2'b00, bclk_halves: 8'd16},
    '{mode: 2'b01, bclk_halves: 8'd8},
    '{mode: 2'b10, bclk_halves: 8'd4},
    '{mode: 2'b11, bclk_halves: 8'd2}
  };

  always #10 clk = ~clk;  // 50 MHz

  audio_frame_clkgen u_dut (
    .mclk_in   (clk),
    .rst_n     (rst_n),
    .speed_sel (speed_sel),
    .mclk_off  (mclk_off),
    .bclk_off  (bclk_off),
    .frame_off (frame_off),
    .mclk_out  (mclk_out),
    .bclk_out  (bclk_out),
    .frame_out (frame_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic align();
    @(posedge clk);
    #5;
    cm = mclk_out; cb = bclk_out; cf = frame_out;
    pm = cm; pb = cb; pf = cf;
  endtask

  task automatic half();
    pm = cm; pb = cb; pf = cf;
    #10;
    cm = mclk_out; cb = bclk_out; cf = frame_out;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  // Measures one frame period from frame rise to frame rise.
  task automatic measure(input int bch, input bit oct, input string tag);
    int guard, n, frh, bhi, mhi, brise, v5, v6, v9;
    align();
    guard = 0;
    while (!(pf == 1'b0 && cf == 1'b1) && guard < 6000) begin
      half();
      guard++;
    end
    n = 1; frh = 1; bhi = int'(cb); mhi = int'(cm); brise = 0;
    v5 = 0; v6 = 0; v9 = (cb != cm) ? 1 : 0;
    for (int k = 0; k < 6000; k++) begin
      half();
      if (cf != pf && !(pb == 1'b1 && cb == 1'b0)) v5++;
      if (pb == 1'b1 && cb == 1'b0 && !(pm == 1'b1 && cm == 1'b0)) v6++;
      if (pf == 1'b0 && cf == 1'b1) break;
      n++;
      frh += int'(cf);
      bhi += int'(cb);
      mhi += int'(cm);
      if (pb == 1'b0 && cb == 1'b1) brise++;
      if (cb != cm) v9++;
    end
    chk({"R1 frame halves ", tag}, n, 64 * bch);
    chk({"R2 bclk periods per frame ", tag}, brise, 64);
    chk({"R2 frame high halves ", tag}, frh, n / 2);
    chk({"R3 bclk high halves ", tag}, bhi, n / 2);
    chk({"R5 frame moves off bclk fall ", tag}, v5, 0);
    chk({"R6 bclk fall without mclk fall ", tag}, v6, 0);
    chk({"R6 mclk high halves ", tag}, mhi, n / 2);
    if (oct) chk({"R9 bclk differs from mclk ", tag}, v9, 0);
  endtask

  initial begin
    rst_n = 1'b0; speed_sel = 2'b00;
    mclk_off = 1'b0; bclk_off = 1'b0; frame_off = 1'b0;

    // R10: reset holds everything low even with every gate requested open.
    begin
      int hi;
      wait_cycles(3);
      align();
      hi = 0;
      for (int k = 0; k < 8; k++) begin
        half();
        hi += int'(cm) + int'(cb) + int'(cf);
      end
      chk("R10 outputs high during reset", hi, 0);
    end
    align();
    rst_n = 1'b1;   // released in the high phase
    half();
    half();         // next high phase, after the first falling edge
    chk("R10 mclk open after first fall", int'(cm), 1);

    // Table walk over every speed code.
    foreach (VECS[i]) begin
      int hi;
      mclk_off = 1'b1; bclk_off = 1'b1; frame_off = 1'b1;
      speed_sel = VECS[i].mode;
      wait_cycles(1100);
      align();
      hi = 0;
      for (int k = 0; k < 200; k++) begin
        half();
        hi += int'(cm) + int'(cb) + int'(cf);
      end
      chk($sformatf("R4 high halves while off mode %0d", i), hi, 0);
      mclk_off = 1'b0; bclk_off = 1'b0; frame_off = 1'b0;
      wait_cycles(1100);
      measure(int'(VECS[i].bclk_halves), (VECS[i].mode == 2'b11),
              $sformatf("mode %0d", i));
    end

    // R7: gates toggled at odd moments in the slowest mode.
    speed_sel = 2'b00;
    wait_cycles(2200);
    begin
      int blen, flen, bviol, fviol, mviol, bruns, fruns;
      bit bstart, fstart;
      align();
      blen = 0; flen = 0; bviol = 0; fviol = 0; mviol = 0;
      bruns = 0; fruns = 0; bstart = 0; fstart = 0;
      for (int i = 0; i < 3000; i++) begin
        case (i)
          37:   bclk_off = 1'b1;
          41:   mclk_off = 1'b1;
          77:   mclk_off = 1'b0;
          90:   bclk_off = 1'b0;
          120:  mclk_off = 1'b1;
          121:  mclk_off = 1'b0;
          151:  bclk_off = 1'b1;
          203:  bclk_off = 1'b0;
          260:  bclk_off = 1'b1;
          300:  frame_off = 1'b1;
          333:  bclk_off = 1'b0;
          1500: frame_off = 1'b0;
          2100: frame_off = 1'b1;
          2600: frame_off = 1'b0;
          default: ;
        endcase
        half();
        if (pm == 1'b1 && cm == 1'b1) mviol++;
        if (pb == 1'b0 && cb == 1'b1) begin blen = 1; bstart = 1; end
        else if (cb == 1'b1) blen++;
        else if (pb == 1'b1 && bstart) begin
          bruns++;
          if (blen != 8) bviol++;
        end
        if (pf == 1'b0 && cf == 1'b1) begin flen = 1; fstart = 1; end
        else if (cf == 1'b1) flen++;
        else if (pf == 1'b1 && fstart) begin
          fruns++;
          if (flen != 512) fviol++;
        end
      end
      chk("R7 short bclk high pulses", bviol, 0);
      chk("R7 bclk pulses seen", int'(bruns > 20), 1);
      chk("R7 mclk high longer than a phase", mviol, 0);
      chk("R7 short frame high pulses", fviol, 0);
      chk("R7 frame pulses seen", int'(fruns >= 1), 1);
    end

    // R4: only the bit clock disabled; the other two keep running.
    bclk_off = 1'b1;
    wait_cycles(20);
    begin
      int bh, mh;
      align();
      bh = 0; mh = 0;
      for (int k = 0; k < 300; k++) begin
        half();
        bh += int'(cb);
        mh += int'(cm);
      end
      chk("R4 bclk high while off", bh, 0);
      chk("R4 mclk unaffected", mh, 150);
    end
    bclk_off = 1'b0;
    wait_cycles(20);

    // R8: speed change while running lands on a frame boundary.
    begin
      int len, viol, newruns;
      bit started;
      align();
      len = 0; viol = 0; newruns = 0; started = 0;
      for (int i = 0; i < 4000; i++) begin
        if (i == 700) speed_sel = 2'b01;
        half();
        if (cf != pf) begin
          if (started) begin
            if (len != 512 && len != 256) viol++;
            if (len == 256) newruns++;
          end
          len = 1;
          started = 1;
        end else begin
          len++;
        end
      end
      chk("R8 mixed frame phases", viol, 0);
      chk("R8 new rate reached", int'(newruns > 0), 1);
    end
    measure(8, 1'b0, "after live change");

    // R10: reset in mid-run with all gates open.
    begin
      int hi;
      align();
      rst_n = 1'b0;
      hi = 0;
      for (int k = 0; k < 10; k++) begin
        half();
        hi += int'(cm) + int'(cb) + int'(cf);
      end
      chk("R10 outputs high in mid-run reset", hi, 0);
      rst_n = 1'b1;
      speed_sel = 2'b00;
      wait_cycles(1100);
      measure(16, 1'b0, "after reset");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_cycles(150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule